// File: doc/BRIEF.md
# Disk Controller Command and Status Unit

This block is the command-side front end of a controller serving a small set of cartridge disk drives (four by default). A host writes a 16-bit command word into a holding register. The block splits that word into a function code and a drive number. On a start strobe it either hands the function to the transfer and positioning logic through a one-cycle launch pulse, or it finishes the function on its own: init, an unknown code, or a function aimed at a drive that is not present.

The block keeps a 16-bit status word for every drive and updates it by fixed rules. Those rules cover starting a seek, init, completion reports from the downstream logic, and drives being attached or removed. The status of the drive named in the command word is always visible, with an any-error bit formed as the word is read out. A read strobe clears that drive's one-shot flags. A separate output gives an attention summary with one bit per drive. It is either loaded on its own or merged with a value supplied on the bus.

Top module: `dk_cmd_status`

## Requirements
- R1: The function code is command bits 15:12 and the drive number is bits 1:0. A start accepted with code 0 (status), 1 (write), 2 (read), 3 (seek), 5 (refine), 6 (check) or 11 (address record) raises `launch` for exactly the next cycle, with `launch_fn` equal to the code and `launch_drv` equal to the drive, and sets `ctrl_busy` and `cmd_active`.
- R2: Status layout: 15 attention, 14 first seek, 13 overrun, 12 r/w unsafe, 11 access unsafe, 10 hunting, 9 seek incomplete, 8 seek error, 6 not ready, 5 end of cylinder, 4 address error, 3 flagged, 2 busy, 1 data error, 0 any-error, 7 always 0. A seek launch sets bit 2 and clears bits 14, 10, 9 and 8 of that drive, leaving the other bits unchanged.
- R3: A start with code 9 (init) sets bit 3 of the addressed drive. In the next cycle `chan_flag` is 1 and `cmd_active` is 0, and there is no launch.
- R4: A start with code 1, 2, 3, 5 or 6 aimed at a drive whose `drive_present` bit is 0 sets that drive's status to exactly 0x0040. It raises `chan_flag`, clears `cmd_active` and does not launch. Codes 0 and 11 launch whether or not the drive is present.
- R5: `status_out` shows the selected drive's status with bit 0 set exactly when any of bits 15:8, 6, 5, 3 or 1 is set. Bits 4 and 2 do not contribute.
- R6: A `stat_rd` strobe clears bits 15, 5, 4, 3 and 1 of the selected drive and leaves the other bits unchanged.
- R7: In `summary_out`, bit i is drive i's attention bit. With `sum_merge` at 0 all other bits are 0. With `sum_merge` at 1 the drive bits are ORed into `bus_in`.
- R8: `cancel` clears `ctrl_busy`, `cmd_active` and the control latch without changing any status. A later start is then accepted.
- R9: A start that arrives while the control latch is set is ignored: no launch and no status change.
- R10: A `done` strobe sets bit 15 of drive `done_drv`, ORs in `done_err` (bit 0 excluded) and clears bit 2. It also sets `chan_flag` and clears `cmd_active` and `ctrl_busy`.
- R11: After reset, `chan_flag` is 1 and `ctrl_busy`, `cmd_active` and `launch` are 0. Each present drive reads 0x4000 and each absent drive reads 0x0040 (before the any-error bit is added).
- R12: When a drive's `drive_present` bit rises, bit 14 is set and bit 6 is cleared. When it falls, bit 6 is set and bit 14 is cleared.
- R13: A start with any other code sets `cmd_active`, does not launch and leaves every status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_present | input | NUM_DRIVES | One bit per drive, 1 when the drive is attached |
| cmd_wr | input | 1 | Load `cmd_in` into the command register |
| cmd_in | input | 16 | Command word |
| start | input | 1 | Start strobe |
| cancel | input | 1 | Clear-control strobe |
| flag_clr | input | 1 | Clear the channel flag |
| stat_rd | input | 1 | Status read strobe for the selected drive |
| done | input | 1 | Operation completion strobe from downstream logic |
| done_drv | input | DRV_W | Drive that completed |
| done_err | input | 16 | Error bits to merge into the completing drive's status |
| bus_in | input | 16 | Bus value for the merge form of the summary |
| sum_merge | input | 1 | 1 merges the summary into `bus_in`, 0 loads it alone |
| launch | output | 1 | One-cycle pulse handing a function downstream |
| launch_fn | output | 4 | Function code of the launch |
| launch_drv | output | DRV_W | Drive of the launch |
| ctrl_busy | output | 1 | Controller occupied by a launched function |
| chan_flag | output | 1 | Command channel flag |
| cmd_active | output | 1 | Command latch |
| status_out | output | 16 | Status of the selected drive with the any-error bit |
| summary_out | output | 16 | Attention summary word |

## Verification
The bench builds the block with four drives and a 16-bit word, with drive 2 absent. This lets one sweep cover all sixteen function codes against every drive, including the absent drive and undefined codes. After each start the bench reports completion, reads the status and cancels, so the set and clear rules and the composite bit are checked from known states. The absent drive is then attached and removed again, and the merge form of the summary and start-while-latched are exercised on a drive with attention pending.

// File: rtl/dk_pkg.sv
package dk_pkg;
   // function codes
   localparam logic [3:0] FN_STAT   = 4'd0;
   localparam logic [3:0] FN_WRITE  = 4'd1;
   localparam logic [3:0] FN_READ   = 4'd2;
   localparam logic [3:0] FN_SEEK   = 4'd3;
   localparam logic [3:0] FN_REFINE = 4'd5;
   localparam logic [3:0] FN_CHECK  = 4'd6;
   localparam logic [3:0] FN_INIT   = 4'd9;
   localparam logic [3:0] FN_ADDR   = 4'd11;

   // status bit masks
   localparam logic [15:0] ST_ATTN  = 16'h8000;
   localparam logic [15:0] ST_FIRST = 16'h4000;
   localparam logic [15:0] ST_NRDY  = 16'h0040;
   localparam logic [15:0] ST_FLAG  = 16'h0008;
   localparam logic [15:0] ST_BUSY  = 16'h0004;
   localparam logic [15:0] ST_ANY   = 16'h0001;
   localparam logic [15:0] ST_SPARE = 16'h0080;

   // groups
   localparam logic [15:0] ERR_GROUP  = 16'hFF6A;
   localparam logic [15:0] RD_CLEAR   = 16'h803A;
   localparam logic [15:0] SEEK_CLEAR = 16'h4700;

   function automatic logic [15:0] with_any(input logic [15:0] s);
      return s | (((s & ERR_GROUP) != 16'h0) ? ST_ANY : 16'h0);
   endfunction
endpackage

// File: rtl/dk_cmd_decode.sv
module dk_cmd_decode
   import dk_pkg::*;
#(
   parameter int DRV_W  = 2,
   parameter int FN_LSB = 12
) (
   input  logic [15:0]      word,
   output logic [3:0]       fn,
   output logic [DRV_W-1:0] drv,
   output logic             is_launch,
   output logic             needs_attach,
   output logic             is_seek,
   output logic             is_init
);
   assign fn  = word[FN_LSB +: 4];
   assign drv = word[DRV_W-1:0];

   always_comb begin
      is_launch    = 1'b0;
      needs_attach = 1'b0;
      is_seek      = 1'b0;
      is_init      = 1'b0;
      unique case (fn)
         FN_STAT, FN_ADDR: is_launch = 1'b1;
         FN_WRITE, FN_READ, FN_REFINE, FN_CHECK: begin
            is_launch    = 1'b1;
            needs_attach = 1'b1;
         end
         FN_SEEK: begin
            is_launch    = 1'b1;
            needs_attach = 1'b1;
            is_seek      = 1'b1;
         end
         FN_INIT: is_init = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/dk_drive_status.sv
module dk_drive_status
   import dk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        present,
   input  logic        done_hit,
   input  logic [15:0] done_err,
   input  logic        seek_go,
   input  logic        init_go,
   input  logic        absent_go,
   input  logic        rd_clr,
   output logic [15:0] st
);
   logic        prev_q;
   logic [15:0] nxt;

   always_comb begin
      nxt = st;
      if (present && !prev_q) nxt = (nxt | ST_FIRST) & ~ST_NRDY;
      if (!present && prev_q) nxt = (nxt | ST_NRDY) & ~ST_FIRST;
      if (done_hit)  nxt = (nxt | ST_ATTN | done_err) & ~ST_BUSY;
      if (seek_go)   nxt = (nxt | ST_BUSY) & ~SEEK_CLEAR;
      if (init_go)   nxt = nxt | ST_FLAG;
      if (absent_go) nxt = ST_NRDY;
      if (rd_clr)    nxt = nxt & ~RD_CLEAR;
      nxt = nxt & ~(ST_ANY | ST_SPARE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= present ? ST_FIRST : ST_NRDY;
         prev_q <= present;
      end else begin
         st     <= nxt;
         prev_q <= present;
      end
   end

   // R2
   seek_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seek_go |=> (st[2] && !st[14] && !st[8]));
   // R6
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> ((st & RD_CLEAR) == 16'h0));
   // R4
   absent_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      absent_go |=> (st == ST_NRDY));
   // R12
   attach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (present && !prev_q && !done_hit) |=> (st[14] && !st[6]));
endmodule

// File: rtl/dk_cmd_status.sv
module dk_cmd_status
   import dk_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int WORD_W     = 16,
   parameter int FN_LSB     = 12,
   localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_DRIVES-1:0] drive_present,
   input  logic                  cmd_wr,
   input  logic [WORD_W-1:0]     cmd_in,
   input  logic                  start,
   input  logic                  cancel,
   input  logic                  flag_clr,
   input  logic                  stat_rd,
   input  logic                  done,
   input  logic [DRV_W-1:0]      done_drv,
   input  logic [WORD_W-1:0]     done_err,
   input  logic [WORD_W-1:0]     bus_in,
   input  logic                  sum_merge,
   output logic                  launch,
   output logic [3:0]            launch_fn,
   output logic [DRV_W-1:0]      launch_drv,
   output logic                  ctrl_busy,
   output logic                  chan_flag,
   output logic                  cmd_active,
   output logic [WORD_W-1:0]     status_out,
   output logic [WORD_W-1:0]     summary_out
);
   if (WORD_W != 16) begin : g_bad_width
      $error("dk_cmd_status: status layout needs a 16-bit word");
   end
   if (NUM_DRIVES < 1 || NUM_DRIVES > 16 || (1 << DRV_W) != NUM_DRIVES) begin : g_bad_drives
      $error("dk_cmd_status: drive count must be a power of two up to 16");
   end

   logic [15:0]      cmd_q;
   logic             ctl_q;
   logic [3:0]       fn;
   logic [DRV_W-1:0] drv;
   logic             is_launch, needs_attach, is_seek, is_init;
   logic             start_acc, launch_go, absent_go, seek_go, init_go, sel_present;
   logic [15:0]      st_arr [NUM_DRIVES];
   logic [NUM_DRIVES-1:0] attn;

   dk_cmd_decode #(.DRV_W(DRV_W), .FN_LSB(FN_LSB)) u_dec (
      .word(cmd_q), .fn(fn), .drv(drv), .is_launch(is_launch),
      .needs_attach(needs_attach), .is_seek(is_seek), .is_init(is_init)
   );

   assign sel_present = drive_present[drv];
   assign start_acc   = start && !ctl_q && !cancel;
   assign launch_go   = start_acc && is_launch && (sel_present || !needs_attach);
   assign absent_go   = start_acc && is_launch && needs_attach && !sel_present;
   assign seek_go     = launch_go && is_seek;
   assign init_go     = start_acc && is_init;

   for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drive
      logic sel;
      assign sel = (drv == DRV_W'(i));
      dk_drive_status u_st (
         .clk(clk), .rst_n(rst_n), .present(drive_present[i]),
         .done_hit(done && (done_drv == DRV_W'(i))),
         .done_err(done_err),
         .seek_go(seek_go && sel), .init_go(init_go && sel),
         .absent_go(absent_go && sel), .rd_clr(stat_rd && sel),
         .st(st_arr[i])
      );
      assign attn[i] = st_arr[i][15];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q      <= '0;
         ctl_q      <= 1'b0;
         cmd_active <= 1'b0;
         ctrl_busy  <= 1'b0;
         chan_flag  <= 1'b1;
         launch     <= 1'b0;
         launch_fn  <= '0;
         launch_drv <= '0;
      end else begin
         if (cmd_wr) cmd_q <= cmd_in;

         if (cancel)         ctl_q <= 1'b0;
         else if (start_acc) ctl_q <= 1'b1;

         if (cancel)         cmd_active <= 1'b0;
         else if (start_acc) cmd_active <= !(init_go || absent_go);
         else if (done)      cmd_active <= 1'b0;

         if (cancel)         ctrl_busy <= 1'b0;
         else if (launch_go) ctrl_busy <= 1'b1;
         else if (done)      ctrl_busy <= 1'b0;

         if (init_go || absent_go || done) chan_flag <= 1'b1;
         else if (flag_clr)                chan_flag <= 1'b0;

         launch <= launch_go;
         if (launch_go) begin
            launch_fn  <= fn;
            launch_drv <= drv;
         end
      end
   end

   assign status_out = with_any(st_arr[drv]);

   always_comb begin
      summary_out = sum_merge ? bus_in : '0;
      for (int i = 0; i < NUM_DRIVES; i++)
         summary_out[i] = summary_out[i] | attn[i];
   end

   // R3
   init_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_go |=> (chan_flag && !cmd_active && !launch));
   // R9
   latched_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ctl_q) |=> !launch);
   // R8
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> (!ctrl_busy && !cmd_active));
   // R10
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_acc && !cancel) |=> (!ctrl_busy && chan_flag && !cmd_active));
   // R1
   launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch);
endmodule

// File: tb/tb_dk_cmd_status.sv
`timescale 1ns/1ps
module tb_dk_cmd_status;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] drive_present = 4'b1011;
   logic        cmd_wr = 0, start = 0, cancel = 0, flag_clr = 0, stat_rd = 0, done = 0;
   logic [15:0] cmd_in = '0, done_err = '0, bus_in = '0;
   logic [1:0]  done_drv = '0;
   logic        sum_merge = 0;
   logic        launch, ctrl_busy, chan_flag, cmd_active;
   logic [3:0]  launch_fn;
   logic [1:0]  launch_drv;
   logic [15:0] status_out, summary_out;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [15:0] ms [N];

   always #4 clk = ~clk;

   dk_cmd_status #(.NUM_DRIVES(N)) dut (
      .clk(clk), .rst_n(rst_n), .drive_present(drive_present), .cmd_wr(cmd_wr),
      .cmd_in(cmd_in), .start(start), .cancel(cancel), .flag_clr(flag_clr),
      .stat_rd(stat_rd), .done(done), .done_drv(done_drv), .done_err(done_err),
      .bus_in(bus_in), .sum_merge(sum_merge), .launch(launch), .launch_fn(launch_fn),
      .launch_drv(launch_drv), .ctrl_busy(ctrl_busy), .chan_flag(chan_flag),
      .cmd_active(cmd_active), .status_out(status_out), .summary_out(summary_out)
   );

   function automatic logic [15:0] anybit(input logic [15:0] s);
      return s | (((s & 16'hFF6A) != 0) ? 16'h1 : 16'h0);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sel(input logic [15:0] w);
      cmd_in = w; cmd_wr = 1; tick(); cmd_wr = 0;
   endtask

   task automatic do_done(input int d, input logic [15:0] e);
      done = 1; done_drv = 2'(d); done_err = e; tick(); done = 0; done_err = '0;
      ms[d] = (ms[d] | 16'h8000 | (e & 16'hFFFE)) & ~16'h0004;
   endtask

   task automatic do_read(input int d);
      stat_rd = 1; tick(); stat_rd = 0;
      ms[d] = ms[d] & ~16'h803A;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk); tick(); tick();
      rst_n = 1; tick();
      for (int d = 0; d < N; d++) ms[d] = drive_present[d] ? 16'h4000 : 16'h0040;
      // R11 reset state
      chk("R11 flag", chan_flag, 1);
      chk("R11 busy", ctrl_busy, 0);
      chk("R11 cmd", cmd_active, 0);
      chk("R11 launch", launch, 0);
      for (int d = 0; d < N; d++) begin
         sel(16'(d));
         chk("R11 status", status_out, anybit(ms[d]));
      end

      // sweep every code against every drive (drive 2 absent)
      for (int f = 0; f < 16; f++) begin
         for (int d = 0; d < N; d++) begin
            bit lc, att, launched, absent, undef;
            lc  = (f inside {0,1,2,3,5,6,11});
            att = (f inside {1,2,3,5,6});
            launched = lc && (drive_present[d] || !att);
            absent   = lc && att && !drive_present[d];
            undef    = !lc && (f != 9);
            flag_clr = 1; tick(); flag_clr = 0;
            sel(16'(f << 12) | 16'(d));
            start = 1; tick(); start = 0;
            if (f == 3 && launched) ms[d] = (ms[d] | 16'h0004) & ~16'h4700;
            if (f == 9) ms[d] = ms[d] | 16'h0008;
            if (absent) ms[d] = 16'h0040;
            chk("R1 launch", launch, launched);
            if (launched) begin
               chk("R1 fn", launch_fn, f);
               chk("R1 drv", launch_drv, d);
               chk("R1 busy", ctrl_busy, 1);
            end
            if (f == 3) chk("R2 seek status", status_out, anybit(ms[d]));
            else if (f == 9) begin
               chk("R3 init status", status_out, anybit(ms[d]));
               chk("R3 init flag", chan_flag, 1);
               chk("R3 init cmd", cmd_active, 0);
            end else if (absent) begin
               chk("R4 absent status", status_out, 16'h0041);
               chk("R4 absent flag", chan_flag, 1);
               chk("R4 absent cmd", cmd_active, 0);
            end else if (undef) begin
               chk("R13 undef status", status_out, anybit(ms[d]));
               chk("R13 undef cmd", cmd_active, 1);
            end else
               chk("R5 status", status_out, anybit(ms[d]));
            if (launched) begin
               do_done(d, 16'h0);
               chk("R10 status", status_out, anybit(ms[d]));
               chk("R10 flag", chan_flag, 1);
               chk("R10 busy", ctrl_busy, 0);
               chk("R7 summary", summary_out, 16'(1 << d));
            end
            do_read(d);
            chk("R6 read clear", status_out, anybit(ms[d]));
            cancel = 1; tick(); cancel = 0;
            chk("R8 busy", ctrl_busy, 0);
            chk("R8 cmd", cmd_active, 0);
         end
      end

      // R12 attach and remove drive 2
      sel(16'h0002);
      drive_present[2] = 1; tick();
      ms[2] = (ms[2] | 16'h4000) & ~16'h0040;
      chk("R12 attach", status_out, anybit(ms[2]));
      drive_present[2] = 0; tick();
      ms[2] = (ms[2] | 16'h0040) & ~16'h4000;
      chk("R12 remove", status_out, anybit(ms[2]));

      // R7 merge, R9 start while latched, R8 cancel keeps status
      sel(16'h0001);
      start = 1; tick(); start = 0;
      do_done(1, 16'h0);
      bus_in = 16'h0F00; sum_merge = 1; #1;
      chk("R7 merge", summary_out, 16'h0F02);
      sum_merge = 0; #1;
      chk("R7 load", summary_out, 16'h0002);
      sel(16'h3001);
      start = 1; tick(); start = 0;
      chk("R9 no launch", launch, 0);
      chk("R9 status", status_out, anybit(ms[1]));
      cancel = 1; tick(); cancel = 0;
      chk("R8 status kept", status_out, anybit(ms[1]));
      chk("R8 busy clear", ctrl_busy, 0);
      do_read(1);

      // R5 / R10 error merge then read keeps non-oneshot bits
      sel(16'h0000);
      start = 1; tick(); start = 0;
      do_done(0, 16'h1011);
      chk("R10 err merge", status_out, anybit(ms[0]));
      do_read(0);
      chk("R6 keeps r/w unsafe", status_out, 16'h1001);
      cancel = 1; tick(); cancel = 0;

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule